// File: doc/BRIEF.md
# OSD Raster Timing and Slice Generator

This block provides the timing for an on-screen display overlay. It runs on the pixel clock and takes already synchronised horizontal flyback and vertical sync signals. For each sync it detects the reference edge the software has selected. From the flyback edge it counts pixels. It opens a horizontal character window between a register-coded start position and the end of the programmed line length. Inside that window it steps a character-cell column from 0 to 11.

The vertical sequencer waits out a top margin measured in groups of four scan lines after each frame start. It then walks a list of strip descriptors supplied from outside. A descriptor is either a text strip, one character height tall, or a spacing strip measured in scan lines or in character heights. For every scan line of a text strip the block scales the line index onto an 18-row glyph font. It also strobes the start of each strip, so the descriptor source can move to its next entry, and the first pixel of each character cell, so the code fetch can move to its next character. A frame counter produces a flashing phase at three selectable rates.

The downstream pixel pipeline uses `disp_active_o`, `col_o`, `slice_o` and `flash_hide_o` to pick a glyph pixel.

Top module: `osd_raster_timer`

## Requirements
- R1: The character window closes at pixel (2·`line_dur_i` + 1)·12 after the horizontal reference edge, so the last active pixel is one less than that count.
- R2: The first active pixel is at 6·d + 18 pixels after the horizontal reference edge. Here d is `h_delay_i` when that value is 8 or more. Otherwise d is 6 for an even value and 7 for an odd value, which gives 54 and 60 pixels.
- R3: Within the window `col_o` starts at 0 on the first active pixel and counts 0 to 11 repeatedly. `next_char_o` is high on each active pixel whose column is 0. Outside the window `col_o` is 0.
- R4: With `hfly_fall_i`=0 the rising flyback edge starts a line, and with 1 the falling edge does. With `vsync_rise_i`=1 the rising vertical edge starts a frame, and with 0 the falling edge does. The opposite edge has no effect.
- R5: After a frame start, the first 4·`top_margin_i` line starts are margin lines. The next line start begins the first strip.
- R6: At the start of each strip line the block samples the descriptor inputs and pulses `new_strip_o` for one cycle, in the cycle that follows the reference edge. A text strip lasts `char_height_i` lines. A spacing strip lasts `strip_span_i` lines when `strip_in_lines_i`=1, and `strip_span_i`·`char_height_i` lines when it is 0. A zero height or span counts as 1.
- R7: During a text strip, `slice_o` = min(17, floor((36·l + h) / (2·h))), where l is the line index within the strip starting at 0 and h is the character height. Outside a text strip `slice_o` is 0.
- R8: `disp_active_o` is low on margin lines, on spacing strips and before the first frame start. When a strip begins while `strip_valid_i`=0, the block produces no strip pulse and keeps `disp_active_o` low until the next frame start.
- R9: With `osd_en_i`=0, `disp_active_o` and `next_char_o` stay low.
- R10: The block counts frame starts in a 7-bit counter from reset. `flash_hide_o` is 0 for `flash_mode_i`=0. For modes 1, 2 and 3 it equals bit 6, bit 5 and bit 4 of that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hfly_i | input | 1 | Synchronised horizontal flyback |
| vsync_i | input | 1 | Synchronised vertical sync |
| hfly_fall_i | input | 1 | 1 selects the falling flyback edge as the line reference |
| vsync_rise_i | input | 1 | 1 selects the rising vertical edge as the frame reference |
| osd_en_i | input | 1 | Overlay enable |
| line_dur_i | input | 6 | Line length code; pixels per line = (2·code+1)·12 |
| h_delay_i | input | 8 | Horizontal start code in 6-pixel steps |
| top_margin_i | input | 8 | Top margin in units of 4 scan lines |
| char_height_i | input | 6 | Text strip height in scan lines |
| flash_mode_i | input | 2 | Flash rate select, 0 = off |
| strip_valid_i | input | 1 | A descriptor is available for the next strip |
| strip_text_i | input | 1 | Descriptor is a text strip |
| strip_in_lines_i | input | 1 | Spacing measured in scan lines rather than character heights |
| strip_span_i | input | 8 | Spacing strip size |
| col_o | output | 4 | Pixel column within the character cell |
| slice_o | output | 5 | Glyph row for the current scan line |
| new_strip_o | output | 1 | One-cycle strobe at the start of a strip |
| next_char_o | output | 1 | Strobe on the first pixel of each displayed cell |
| disp_active_o | output | 1 | Current pixel lies in a displayed text cell |
| flash_hide_o | output | 1 | Flashing characters are in their hidden phase |

## Verification
A frame reference edge and a line reference edge can arrive in the same clock cycle. In that case the frame restart must win, and that line must not count as a margin line. The bench forces this by raising flyback and dropping vertical sync on the same clock edge with a one-unit margin. It then requires the first displayed line to be the fifth line start after it and not the fourth. The same edge must also advance the flash counter, and the later flash checks depend on that count.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;

  typedef enum logic [1:0] {
    V_IDLE   = 2'd0,
    V_MARGIN = 2'd1,
    V_STRIP  = 2'd2,
    V_DONE   = 2'd3
  } vstate_e;

  localparam int DLY_STEP = 6;   // pixels per delay code step
  localparam int DLY_BASE = 54;  // pixels at the reference code
  localparam int DLY_REF  = 6;   // code giving DLY_BASE

endpackage

// File: rtl/osd_edge_pick.sv
module osd_edge_pick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic prev_q;
  logic vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= sig_i;
      vld_q  <= 1'b1;
    end
  end

  // vld_q masks the first cycle so a held level is not taken as an edge
  always_comb begin
    if (fall_sel_i) edge_o = vld_q & prev_q & ~sig_i;
    else            edge_o = vld_q & ~prev_q & sig_i;
  end
endmodule

// File: rtl/osd_hwindow.sv
module osd_hwindow #(
  parameter int LD_W   = 6,
  parameter int DD_W   = 8,
  parameter int PX_W   = 11,
  parameter int CELL_W = 12,
  parameter int COL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [LD_W-1:0]   line_dur_i,
  input  logic [DD_W-1:0]   h_delay_i,
  output logic              in_win_o,
  output logic [COL_W-1:0]  col_o,
  output logic              char_start_o
);
  import osd_raster_pkg::*;

  localparam int LW       = PX_W + 1;
  localparam int DLY_OFS  = DLY_BASE - DLY_REF * DLY_STEP;
  localparam int ODD_MIN  = DLY_REF + 1;

  logic [PX_W-1:0]  px_q;
  logic [COL_W-1:0] col_q;
  logic [LW-1:0]    line_len;
  logic [LW-1:0]    first_px;
  logic [DD_W-1:0]  dd_eff;

  always_comb begin
    line_len = LW'({line_dur_i, 1'b1}) * LW'(CELL_W);
    if (h_delay_i <= DD_W'(ODD_MIN))
      dd_eff = h_delay_i[0] ? DD_W'(ODD_MIN) : DD_W'(DLY_REF);
    else
      dd_eff = h_delay_i;
    first_px = LW'(dd_eff) * LW'(DLY_STEP) + LW'(DLY_OFS);
  end

  assign in_win_o = (LW'(px_q) >= first_px) && (LW'(px_q) < line_len);

  // pixel counter saturates so the window stays shut if flyback stops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px_q <= '1;
    end else if (line_start_i) begin
      px_q <= '0;
    end else if (px_q != '1) begin
      px_q <= px_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
    end else if (line_start_i) begin
      col_q <= '0;
    end else if (in_win_o) begin
      col_q <= (col_q == COL_W'(CELL_W - 1)) ? '0 : col_q + 1'b1;
    end
  end

  assign col_o        = in_win_o ? col_q : '0;
  assign char_start_o = in_win_o && (col_q == '0);
endmodule

// File: rtl/osd_vseq.sv
module osd_vseq #(
  parameter int TM_W     = 8,
  parameter int CH_W     = 6,
  parameter int SPAN_W   = 8,
  parameter int MG_SHIFT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  input  logic [TM_W-1:0]   top_margin_i,
  input  logic [CH_W-1:0]   char_height_i,
  input  logic              strip_valid_i,
  input  logic              strip_text_i,
  input  logic              strip_in_lines_i,
  input  logic [SPAN_W-1:0] strip_span_i,
  output logic              text_line_o,
  output logic              new_strip_o,
  output logic [CH_W-1:0]   line_idx_o
);
  import osd_raster_pkg::*;

  localparam int MG_W  = TM_W + MG_SHIFT;
  localparam int LEN_W = SPAN_W + CH_W;

  vstate_e           state_q;
  logic [MG_W-1:0]   mleft_q;
  logic [LEN_W-1:0]  line_q;
  logic [LEN_W-1:0]  last_q;
  logic              text_q;
  logic              new_q;

  logic [CH_W-1:0]   ch_eff;
  logic [SPAN_W-1:0] span_eff;
  logic [LEN_W-1:0]  strip_len;
  logic              start_req;

  always_comb begin
    ch_eff   = (char_height_i == '0) ? CH_W'(1) : char_height_i;
    span_eff = (strip_span_i == '0) ? SPAN_W'(1) : strip_span_i;
    if (strip_text_i)          strip_len = LEN_W'(ch_eff);
    else if (strip_in_lines_i) strip_len = LEN_W'(span_eff);
    else                       strip_len = LEN_W'(span_eff) * LEN_W'(ch_eff);
    start_req = ((state_q == V_MARGIN) && (mleft_q == '0)) ||
                ((state_q == V_STRIP) && (line_q == last_q));
  end

  // frame start outranks a line start in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= V_IDLE;
      mleft_q <= '0;
      line_q  <= '0;
      last_q  <= '0;
      text_q  <= 1'b0;
      new_q   <= 1'b0;
    end else begin
      new_q <= 1'b0;
      if (frame_start_i) begin
        state_q <= V_MARGIN;
        mleft_q <= {top_margin_i, {MG_SHIFT{1'b0}}};
        line_q  <= '0;
        text_q  <= 1'b0;
      end else if (line_start_i) begin
        if (start_req) begin
          if (strip_valid_i) begin
            state_q <= V_STRIP;
            text_q  <= strip_text_i;
            last_q  <= strip_len - 1'b1;
            line_q  <= '0;
            new_q   <= 1'b1;
          end else begin
            state_q <= V_DONE;
            text_q  <= 1'b0;
          end
        end else if (state_q == V_MARGIN) begin
          mleft_q <= mleft_q - 1'b1;
        end else if (state_q == V_STRIP) begin
          line_q <= line_q + 1'b1;
        end
      end
    end
  end

  assign text_line_o = (state_q == V_STRIP) && text_q;
  assign new_strip_o = new_q;
  assign line_idx_o  = line_q[CH_W-1:0];
endmodule

// File: rtl/osd_slice_scale.sv
module osd_slice_scale #(
  parameter int CH_W    = 6,
  parameter int SLICE_N = 18,
  parameter int SL_W    = 5
) (
  input  logic [CH_W-1:0] line_idx_i,
  input  logic [CH_W-1:0] char_height_i,
  output logic [SL_W-1:0] slice_o
);
  localparam int NUM_W = CH_W + $clog2(2 * SLICE_N) + 1;

  logic [CH_W-1:0]  ch_eff;
  logic [NUM_W-1:0] num;
  logic [NUM_W-1:0] den;
  logic [NUM_W-1:0] quo;

  // round(l*N/h) computed as floor((2*N*l + h) / (2*h))
  always_comb begin
    ch_eff = (char_height_i == '0) ? CH_W'(1) : char_height_i;
    num    = NUM_W'(line_idx_i) * NUM_W'(2 * SLICE_N) + NUM_W'(ch_eff);
    den    = NUM_W'(ch_eff) << 1;
    quo    = num / den;
    if (quo > NUM_W'(SLICE_N - 1)) slice_o = SL_W'(SLICE_N - 1);
    else                           slice_o = quo[SL_W-1:0];
  end
endmodule

// File: rtl/osd_flash.sv
module osd_flash #(
  parameter int FC_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_start_i,
  input  logic [1:0] mode_i,
  output logic       hide_o
);
  logic [FC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (frame_start_i) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      2'd1:    hide_o = cnt_q[FC_W-1];
      2'd2:    hide_o = cnt_q[FC_W-2];
      2'd3:    hide_o = cnt_q[FC_W-3];
      default: hide_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/osd_raster_timer.sv
module osd_raster_timer #(
  parameter int LD_W    = 6,
  parameter int DD_W    = 8,
  parameter int TM_W    = 8,
  parameter int CH_W    = 6,
  parameter int SPAN_W  = 8,
  parameter int PX_W    = 11,
  parameter int FC_W    = 7,
  parameter int CELL_W  = 12,
  parameter int SLICE_N = 18,
  localparam int COL_W  = $clog2(CELL_W),
  localparam int SL_W   = $clog2(SLICE_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hfly_i,
  input  logic              vsync_i,
  input  logic              hfly_fall_i,
  input  logic              vsync_rise_i,
  input  logic              osd_en_i,
  input  logic [LD_W-1:0]   line_dur_i,
  input  logic [DD_W-1:0]   h_delay_i,
  input  logic [TM_W-1:0]   top_margin_i,
  input  logic [CH_W-1:0]   char_height_i,
  input  logic [1:0]        flash_mode_i,
  input  logic              strip_valid_i,
  input  logic              strip_text_i,
  input  logic              strip_in_lines_i,
  input  logic [SPAN_W-1:0] strip_span_i,
  output logic [COL_W-1:0]  col_o,
  output logic [SL_W-1:0]   slice_o,
  output logic              new_strip_o,
  output logic              next_char_o,
  output logic              disp_active_o,
  output logic              flash_hide_o
);
  logic line_start;
  logic frame_start;
  logic in_win;
  logic char_start;
  logic text_line;
  logic [COL_W-1:0] col;
  logic [CH_W-1:0]  line_idx;
  logic [SL_W-1:0]  slice;

  osd_edge_pick i_hedge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sig_i      (hfly_i),
    .fall_sel_i (hfly_fall_i),
    .edge_o     (line_start)
  );

  osd_edge_pick i_vedge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sig_i      (vsync_i),
    .fall_sel_i (~vsync_rise_i),
    .edge_o     (frame_start)
  );

  osd_hwindow #(
    .LD_W(LD_W), .DD_W(DD_W), .PX_W(PX_W), .CELL_W(CELL_W), .COL_W(COL_W)
  ) i_hwin (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start),
    .line_dur_i   (line_dur_i),
    .h_delay_i    (h_delay_i),
    .in_win_o     (in_win),
    .col_o        (col),
    .char_start_o (char_start)
  );

  osd_vseq #(
    .TM_W(TM_W), .CH_W(CH_W), .SPAN_W(SPAN_W)
  ) i_vseq (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .frame_start_i    (frame_start),
    .line_start_i     (line_start),
    .top_margin_i     (top_margin_i),
    .char_height_i    (char_height_i),
    .strip_valid_i    (strip_valid_i),
    .strip_text_i     (strip_text_i),
    .strip_in_lines_i (strip_in_lines_i),
    .strip_span_i     (strip_span_i),
    .text_line_o      (text_line),
    .new_strip_o      (new_strip_o),
    .line_idx_o       (line_idx)
  );

  osd_slice_scale #(
    .CH_W(CH_W), .SLICE_N(SLICE_N), .SL_W(SL_W)
  ) i_slice (
    .line_idx_i    (line_idx),
    .char_height_i (char_height_i),
    .slice_o       (slice)
  );

  osd_flash #(.FC_W(FC_W)) i_flash (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start),
    .mode_i        (flash_mode_i),
    .hide_o        (flash_hide_o)
  );

  assign col_o         = col;
  assign slice_o       = text_line ? slice : '0;
  assign disp_active_o = osd_en_i && text_line && in_win;
  assign next_char_o   = disp_active_o && char_start;
endmodule

// File: rtl/osd_raster_timer_chk.sv
module osd_raster_timer_chk #(
  parameter int COL_W   = 4,
  parameter int SL_W    = 5,
  parameter int CELL_W  = 12,
  parameter int SLICE_N = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             osd_en_i,
  input logic [1:0]       flash_mode_i,
  input logic [COL_W-1:0] col_o,
  input logic [SL_W-1:0]  slice_o,
  input logic             new_strip_o,
  input logic             next_char_o,
  input logic             disp_active_o,
  input logic             flash_hide_o
);
  assert_col_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_o <= COL_W'(CELL_W - 1));

  assert_cell_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_char_o |-> (col_o == '0) && disp_active_o);

  assert_col_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_active_o && $past(disp_active_o) && !next_char_o)
      |-> col_o == $past(col_o) + 1'b1);

  assert_slice_max_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slice_o <= SL_W'(SLICE_N - 1));

  assert_off_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osd_en_i |-> !disp_active_o && !next_char_o);

  assert_strip_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_strip_o |=> !new_strip_o);

  assert_flash_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_mode_i == 2'd0) |-> !flash_hide_o);
endmodule

bind osd_raster_timer osd_raster_timer_chk #(
  .COL_W(COL_W), .SL_W(SL_W), .CELL_W(CELL_W), .SLICE_N(SLICE_N)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .osd_en_i      (osd_en_i),
  .flash_mode_i  (flash_mode_i),
  .col_o         (col_o),
  .slice_o       (slice_o),
  .new_strip_o   (new_strip_o),
  .next_char_o   (next_char_o),
  .disp_active_o (disp_active_o),
  .flash_hide_o  (flash_hide_o)
);

// File: tb/test_osd_raster_timer.sv
module test_osd_raster_timer;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_CYC   = 200;
  localparam int NROW       = 9;
  // line_dur, h_delay, first active pixel, active pixels, cells
  localparam int TBL [NROW][5] = '{
    '{5, 0,  54, 78, 7},
    '{5, 5,  60, 72, 6},
    '{5, 6,  54, 78, 7},
    '{5, 7,  60, 72, 6},
    '{5, 8,  66, 66, 6},
    '{5, 15, 108, 24, 2},
    '{3, 9,  72, 12, 1},
    '{3, 2,  54, 30, 3},
    '{7, 20, 138, 42, 4}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hfly = 1'b0, vsync = 1'b0;
  logic hfly_fall = 1'b0, vsync_rise = 1'b1, osd_en = 1'b1;
  logic [5:0] line_dur = 6'd5;
  logic [7:0] h_delay = 8'd0, top_margin = 8'd0, strip_span = 8'd0;
  logic [5:0] char_height = 6'd63;
  logic [1:0] flash_mode = 2'd0;
  logic strip_valid = 1'b0, strip_text = 1'b0, strip_in_lines = 1'b0;
  logic [3:0] col_o;
  logic [4:0] slice_o;
  logic new_strip_o, next_char_o, disp_active_o, flash_hide_o;

  int checks = 0, errors = 0;
  int nv = 0;
  logic vidle = 1'b0;
  int d_text [4], d_lines [4], d_span [4];
  int d_n = 0, d_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_raster_timer i_osd_raster_timer (
    .clk_i(clk), .rst_ni(rst_ni), .hfly_i(hfly), .vsync_i(vsync),
    .hfly_fall_i(hfly_fall), .vsync_rise_i(vsync_rise), .osd_en_i(osd_en),
    .line_dur_i(line_dur), .h_delay_i(h_delay), .top_margin_i(top_margin),
    .char_height_i(char_height), .flash_mode_i(flash_mode),
    .strip_valid_i(strip_valid), .strip_text_i(strip_text),
    .strip_in_lines_i(strip_in_lines), .strip_span_i(strip_span),
    .col_o(col_o), .slice_o(slice_o), .new_strip_o(new_strip_o),
    .next_char_o(next_char_o), .disp_active_o(disp_active_o),
    .flash_hide_o(flash_hide_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_slice(input int l, input int h);
    int q;
    q = (36 * l + h) / (2 * h);
    return (q > 17) ? 17 : q;
  endfunction

  task automatic apply_desc();
    if (d_idx < d_n) begin
      strip_valid    = 1'b1;
      strip_text     = d_text[d_idx][0];
      strip_in_lines = d_lines[d_idx][0];
      strip_span     = 8'(d_span[d_idx]);
    end else begin
      strip_valid = 1'b0;
    end
  endtask

  task automatic set_desc(input int i, input int t, input int ln, input int sp);
    d_text[i] = t; d_lines[i] = ln; d_span[i] = sp;
  endtask

  task automatic vpulse();
    @(negedge clk); vsync = ~vidle;
    @(negedge clk); vsync = vidle;
    nv++;
    @(negedge clk);
  endtask

  task automatic run_line(input bit with_vs, output int first, output int cnt,
                          output int nch, output int ns, output int sl0,
                          output int col_first);
    first = -1; cnt = 0; nch = 0; ns = 0; sl0 = 0; col_first = -1;
    @(negedge clk);
    hfly = 1'b1;
    if (with_vs) begin vsync = ~vidle; nv++; end
    for (int k = 0; k < LINE_CYC; k++) begin
      @(negedge clk);
      if (k == 0) begin
        hfly = 1'b0;
        if (with_vs) vsync = vidle;
        sl0 = int'(slice_o);
      end
      if (new_strip_o) ns++;
      if (disp_active_o) begin
        if (first < 0) begin first = k; col_first = int'(col_o); end
        cnt++;
      end
      if (next_char_o) nch++;
    end
    if (ns != 0) begin d_idx++; apply_desc(); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f, c, n, s, sl, cf, lidx;
    repeat (3) @(negedge clk);
    // reset state
    chk("R8 reset disp_active", int'(disp_active_o), 0);
    chk("R6 reset new_strip", int'(new_strip_o), 0);
    chk("R3 reset col", int'(col_o), 0);
    chk("R7 reset slice", int'(slice_o), 0);
    chk("R10 reset flash_hide", int'(flash_hide_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R8: no frame start yet, nothing displayed
    d_n = 1; d_idx = 0; set_desc(0, 1, 0, 0); apply_desc();
    run_line(1'b0, f, c, n, s, sl, cf);
    chk("R8 before first frame", c, 0);

    // horizontal table inside one tall text strip
    vpulse();
    lidx = 0;
    for (int i = 0; i < NROW; i++) begin
      line_dur = 6'(TBL[i][0]);
      h_delay  = 8'(TBL[i][1]);
      run_line(1'b0, f, c, n, s, sl, cf);
      chk("R2 first active pixel", f, TBL[i][2]);
      chk("R1 active pixel count", c, TBL[i][3]);
      chk("R3 cell strobes", n, TBL[i][4]);
      chk("R3 column at first pixel", cf, 0);
      chk("R7 slice", sl, exp_slice(lidx, 63));
      if (i == 0) chk("R6 strip pulse on first strip line", s, 1);
      lidx++;
    end

    // R4: falling flyback edge selected, pulse trailing edge starts the line
    line_dur = 6'd5; h_delay = 8'd0; hfly_fall = 1'b1;
    run_line(1'b0, f, c, n, s, sl, cf);
    chk("R4 flyback falling edge select", f, 55);
    hfly_fall = 1'b0; lidx++;

    // R9: overlay disabled
    osd_en = 1'b0;
    run_line(1'b0, f, c, n, s, sl, cf);
    chk("R9 disabled active count", c, 0);
    chk("R9 disabled cell strobes", n, 0);
    osd_en = 1'b1; lidx++;

    // R7: rest of strip, clamp at the bottom
    while (lidx < 63) begin
      run_line(1'b0, f, c, n, s, sl, cf);
      if (lidx == 62) chk("R7 slice clamp at last line", sl, 17);
      else if (lidx % 8 == 3) chk("R7 slice scaling", sl, exp_slice(lidx, 63));
      lidx++;
    end
    // R8: list exhausted
    run_line(1'b0, f, c, n, s, sl, cf);
    chk("R8 exhausted list no display", c, 0);
    chk("R8 exhausted list no strip pulse", s, 0);

    // R5/R6/R8: margin, text, spacing in lines, spacing in heights, text
    top_margin = 8'd1; char_height = 6'd3;
    d_n = 4; d_idx = 0;
    set_desc(0, 1, 0, 0); set_desc(1, 0, 1, 2);
    set_desc(2, 0, 0, 1); set_desc(3, 1, 0, 0);
    apply_desc();
    vpulse();
    for (int ln = 0; ln < 18; ln++) begin
      bit act;
      bit nsx;
      act = (ln >= 4 && ln <= 6) || (ln >= 12 && ln <= 14);
      nsx = (ln == 4) || (ln == 7) || (ln == 9) || (ln == 12);
      run_line(1'b0, f, c, n, s, sl, cf);
      if (ln < 4) chk("R5 margin line inactive", c, 0);
      else if (act) chk("R6 text strip line active", c, 78);
      else chk("R8 spacing or done inactive", c, 0);
      chk("R6 strip pulse placement", s, int'(nsx));
      if (ln >= 4 && ln <= 6) chk("R7 slice short strip", sl, exp_slice(ln - 4, 3));
    end

    // R4: vertical polarity, rising edge ignored when falling selected
    vsync_rise = 1'b0;
    @(negedge clk); vsync = 1'b1; vidle = 1'b1;
    d_n = 1; d_idx = 0; set_desc(0, 1, 0, 0); apply_desc();
    run_line(1'b0, f, c, n, s, sl, cf);
    chk("R4 unselected vertical edge ignored", c, 0);
    @(negedge clk); vsync = 1'b0; nv++;
    @(negedge clk); vsync = 1'b1;
    for (int ln = 0; ln < 5; ln++) begin
      run_line(1'b0, f, c, n, s, sl, cf);
      chk("R4 falling vertical edge starts frame", c, (ln == 4) ? 78 : 0);
    end

    // R5: frame and line edge in the same cycle, frame wins
    d_idx = 0; apply_desc();
    run_line(1'b1, f, c, n, s, sl, cf);
    for (int ln = 0; ln < 5; ln++) begin
      run_line(1'b0, f, c, n, s, sl, cf);
      chk("R5 coincident edges margin count", c, (ln == 4) ? 78 : 0);
    end

    // R10: flashing phases
    while (nv < 80) begin
      vpulse();
      if (nv == 16 || nv == 32 || nv == 64 || nv == 80) begin
        for (int m = 0; m < 4; m++) begin
          int e;
          flash_mode = 2'(m);
          @(negedge clk);
          e = (m == 0) ? 0 : ((nv >> (7 - m)) & 1);
          chk("R10 flash phase", int'(flash_hide_o), e);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule